// File: doc/BRIEF.md
# Radio packet transmit assembler

This block turns the contents of a small transmit buffer into the ordered symbol stream that a radio modulator consumes. The host writes up to sixteen payload bytes into the buffer in one burst, sets the payload length, the data mode, the number of preamble units and the checksum options, and pulses a start strobe. The block then sends the whole packet without further host help. It emits the preamble units, the two start-of-packet symbols, the length byte, the payload bytes and, when enabled, a 16-bit checksum. Each symbol carries a type tag, so the modulator knows which code or framing to apply.

The length byte, the payload and the checksum are sliced into data symbols at the rate the mode selects. Every symbol crosses a valid/ready handshake, so the modulator can pace the block. When the last symbol has been taken, the block pulses a done flag and is ready for the next packet. While a packet is in flight the block reports busy. It ignores any buffer write and any new start strobe during that time.

Top module: `tx_pkt_assembler`

## Requirements
- R1: While reset is asserted (asynchronous, active low) and in the cycle after it is released, sym_valid, busy and done are 0. A reset in the middle of a packet aborts the packet at once.
- R2: A packet starts with cfg_pre preamble symbols (type 0), then one symbol of type 1 and one symbol of type 2, then data symbols of type 3. When cfg_pre is 0 there are no preamble symbols. Symbols other than data symbols carry sym_data 0.
- R3: The data bytes go out in this order: the length byte, then payload bytes from buffer address 0 upward, then the checksum high byte and the checksum low byte.
- R4: Each byte is sent MSB first. Mode 0 sends 8 bits per symbol in sym_data[7:0]. Mode 1 sends 2 bits per symbol in sym_data[1:0]. Modes 2 and 3 (unspread raw bits) send 1 bit per symbol in sym_data[0]. Unused sym_data bits are 0.
- R5: The checksum uses polynomial 0x8005 and is computed MSB first over the payload bytes only, with no final inversion. Its start value is cfg_seed when cfg_seed_sel is 1 and zero when it is 0. With cfg_crc_en at 0 no checksum bytes are sent.
- R6: A cfg_len above 16 is treated as 16, both in the length byte and in the number of payload bytes sent.
- R7: While sym_valid is 1 and sym_ready is 0, the symbol type and data hold steady and no symbol is lost.
- R8: busy is 1 from the cycle after an accepted go until the last symbol is taken. Buffer writes and go strobes seen while busy have no effect.
- R9: done is a one-cycle pulse in the cycle after the last symbol handshake. In that cycle sym_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Buffer write enable |
| wr_addr | input | 4 | Buffer write address |
| wr_data | input | 8 | Buffer write byte |
| cfg_len | input | 5 | Payload length in bytes |
| cfg_mode | input | 2 | Data mode: 0 = 8 bit, 1 = 2 bit, 2 = 1 bit, 3 = raw 1 bit |
| cfg_pre | input | 4 | Number of preamble symbols |
| cfg_crc_en | input | 1 | Append checksum |
| cfg_seed_sel | input | 1 | 1 = start from cfg_seed, 0 = start from zero |
| cfg_seed | input | 16 | Configured checksum start value |
| go | input | 1 | Start strobe, taken when idle |
| sym_valid | output | 1 | Symbol available |
| sym_ready | input | 1 | Modulator takes the symbol |
| sym_type | output | 2 | 0 preamble, 1 first SOP, 2 second SOP, 3 data |
| sym_data | output | 8 | Data bits, right aligned |
| busy | output | 1 | Packet in flight |
| done | output | 1 | One-cycle end-of-packet pulse |

## Verification
A fault in the sequencing state shows up in the type tag of the very next handshake: a miscounted preamble, a skipped or repeated start symbol, or a premature return to idle. A slip in the chunk counter or the shift register corrupts the data symbol that is taken next. An error in the checksum register hides until the two trailing data bytes, so every vector compares the full stream up to and including those bytes and the done pulse. Ignored writes are caught on the following packet, which reuses the buffer contents without reloading them.

// File: rtl/tx_asm_pkg.sv
package tx_asm_pkg;

   typedef enum logic [1:0] {
      SYM_PRE  = 2'd0,
      SYM_SOP1 = 2'd1,
      SYM_SOP2 = 2'd2,
      SYM_DATA = 2'd3
   } sym_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_SOP1,
      ST_SOP2,
      ST_DATA
   } fsm_e;

   localparam logic [1:0] MODE_B8  = 2'd0;
   localparam logic [1:0] MODE_B2  = 2'd1;
   localparam logic [1:0] MODE_B1  = 2'd2;
   localparam logic [1:0] MODE_RAW = 2'd3;

   // one byte through an MSB-first, non-reflected CRC register
   function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                              input logic [7:0]  b,
                                              input logic [15:0] poly);
      logic [15:0] c;
      logic        fb;
      c = crc_in;
      for (int i = 7; i >= 0; i--) begin
         fb = c[15] ^ b[i];
         c  = {c[14:0], 1'b0};
         if (fb) c = c ^ poly;
      end
      return c;
   endfunction

endpackage

// File: rtl/tx_buffer.sv
module tx_buffer #(
   parameter int DEPTH = 16,
   parameter int AW    = 4,
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] rows [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         logic [DW-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we && (waddr == AW'(e)))
               q <= wdata;
         end
         assign rows[e] = q;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < DEPTH; i++)
         if (raddr == AW'(i)) rdata = rows[i];
   end

endmodule

// File: rtl/tx_crc16.sv
module tx_crc16 import tx_asm_pkg::*; #(
   parameter logic [15:0] POLY = 16'h8005
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic [15:0] init_val,
   input  logic        upd,
   input  logic [7:0]  din,
   output logic [15:0] crc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc <= '0;
      else if (init)
         crc <= init_val;
      else if (upd)
         crc <= crc16_byte(crc, din, POLY);
   end

endmodule

// File: rtl/tx_chunker.sv
module tx_chunker import tx_asm_pkg::*; #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [BW-1:0] byte_in,
   input  logic [1:0]    mode,
   input  logic          adv,
   output logic [BW-1:0] chunk,
   output logic          last
);

   localparam int CW = $clog2(BW);

   logic [BW-1:0] sh_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last_idx;

   always_comb begin
      case (mode)
         MODE_B8: last_idx = '0;
         MODE_B2: last_idx = CW'(BW / 2 - 1);
         default: last_idx = CW'(BW - 1);
      endcase
   end

   assign last = (cnt_q == last_idx);

   always_comb begin
      chunk = '0;
      case (mode)
         MODE_B8: chunk = sh_q;
         MODE_B2: chunk[1:0] = sh_q[BW-1 -: 2];
         default: chunk[0] = sh_q[BW-1];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (load) begin
         sh_q  <= byte_in;
         cnt_q <= '0;
      end else if (adv) begin
         cnt_q <= cnt_q + 1'b1;
         if (mode == MODE_B2)
            sh_q <= {sh_q[BW-3:0], 2'b00};
         else
            sh_q <= {sh_q[BW-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/tx_pkt_assembler.sv
module tx_pkt_assembler import tx_asm_pkg::*; #(
   parameter int          BUF_BYTES = 16,
   parameter int          PRE_W     = 4,
   parameter bit          HAS_CRC   = 1'b1,
   parameter logic [15:0] CRC_POLY  = 16'h8005,
   localparam int         AW        = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1,
   localparam int         LEN_W     = $clog2(BUF_BYTES + 1),
   localparam int         IW        = LEN_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [7:0]       wr_data,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic [1:0]       cfg_mode,
   input  logic [PRE_W-1:0] cfg_pre,
   input  logic             cfg_crc_en,
   input  logic             cfg_seed_sel,
   input  logic [15:0]      cfg_seed,
   input  logic             go,
   output logic             sym_valid,
   input  logic             sym_ready,
   output logic [1:0]       sym_type,
   output logic [7:0]       sym_data,
   output logic             busy,
   output logic             done
);

   generate
      if (BUF_BYTES < 1 || BUF_BYTES > 255) begin : g_bad_depth
         $error("tx_pkt_assembler: BUF_BYTES must lie in 1..255");
      end
      if (PRE_W < 1) begin : g_bad_pre
         $error("tx_pkt_assembler: PRE_W must be at least 1");
      end
   endgenerate

   fsm_e             st_q;
   logic [PRE_W-1:0] pre_q;
   logic [LEN_W-1:0] len_q;
   logic [1:0]       mode_q;
   logic             crc_on_q;
   logic [IW-1:0]    idx_q;
   logic             done_q;

   logic             fire;
   logic             accept;
   logic [LEN_W-1:0] len_clamped;
   logic [IW-1:0]    last_byte_idx;
   logic             at_last_byte;
   logic             chunk_last;
   logic [7:0]       chunk;
   logic             load_first;
   logic             load_next;
   logic             load;
   logic [IW-1:0]    load_idx;
   logic             is_payload;
   logic [AW-1:0]    buf_raddr;
   logic [7:0]       buf_rdata;
   logic [7:0]       next_byte;
   logic [15:0]      crc_val;
   logic             crc_allowed;
   logic             adv;

   assign fire   = sym_valid && sym_ready;
   assign accept = go && (st_q == ST_IDLE);

   assign len_clamped = (int'(cfg_len) > BUF_BYTES) ? LEN_W'(BUF_BYTES) : cfg_len;

   assign last_byte_idx = IW'(len_q) + (crc_on_q ? IW'(2) : IW'(0));
   assign at_last_byte  = (idx_q == last_byte_idx);

   assign load_first = fire && (st_q == ST_SOP2);
   assign load_next  = fire && (st_q == ST_DATA) && chunk_last && !at_last_byte;
   assign load       = load_first || load_next;
   assign load_idx   = load_first ? '0 : idx_q + 1'b1;
   assign adv        = fire && (st_q == ST_DATA) && !chunk_last;

   assign is_payload = (load_idx != '0) && (load_idx <= IW'(len_q));
   assign buf_raddr  = AW'(load_idx - 1'b1);

   // byte selector: length, payload, checksum high, checksum low
   always_comb begin
      if (load_idx == '0)
         next_byte = 8'(len_q);
      else if (is_payload)
         next_byte = buf_rdata;
      else if (load_idx == IW'(len_q) + IW'(1))
         next_byte = crc_val[15:8];
      else
         next_byte = crc_val[7:0];
   end

   tx_buffer #(
      .DEPTH (BUF_BYTES),
      .AW    (AW),
      .DW    (8)
   ) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en && !busy),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (buf_raddr),
      .rdata (buf_rdata)
   );

   generate
      if (HAS_CRC) begin : g_crc
         tx_crc16 #(
            .POLY (CRC_POLY)
         ) u_crc (
            .clk      (clk),
            .rst_n    (rst_n),
            .init     (accept),
            .init_val (cfg_seed_sel ? cfg_seed : 16'h0000),
            .upd      (load && is_payload),
            .din      (buf_rdata),
            .crc      (crc_val)
         );
         assign crc_allowed = 1'b1;
      end else begin : g_no_crc
         assign crc_val     = '0;
         assign crc_allowed = 1'b0;
      end
   endgenerate

   tx_chunker #(
      .BW (8)
   ) u_chunk (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .byte_in (next_byte),
      .mode    (mode_q),
      .adv     (adv),
      .chunk   (chunk),
      .last    (chunk_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         pre_q    <= '0;
         len_q    <= '0;
         mode_q   <= MODE_B8;
         crc_on_q <= 1'b0;
         idx_q    <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (go) begin
                  len_q    <= len_clamped;
                  mode_q   <= cfg_mode;
                  crc_on_q <= cfg_crc_en && crc_allowed;
                  pre_q    <= cfg_pre;
                  st_q     <= (cfg_pre == '0) ? ST_SOP1 : ST_PRE;
               end
            end
            ST_PRE: begin
               if (fire) begin
                  if (pre_q == PRE_W'(1))
                     st_q <= ST_SOP1;
                  pre_q <= pre_q - 1'b1;
               end
            end
            ST_SOP1: begin
               if (fire) st_q <= ST_SOP2;
            end
            ST_SOP2: begin
               if (fire) begin
                  st_q  <= ST_DATA;
                  idx_q <= '0;
               end
            end
            ST_DATA: begin
               if (fire && chunk_last) begin
                  if (at_last_byte) begin
                     st_q   <= ST_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     idx_q <= load_idx;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st_q)
         ST_PRE:  sym_type = SYM_PRE;
         ST_SOP1: sym_type = SYM_SOP1;
         ST_SOP2: sym_type = SYM_SOP2;
         ST_DATA: sym_type = SYM_DATA;
         default: sym_type = SYM_PRE;
      endcase
   end

   assign sym_valid = (st_q != ST_IDLE);
   assign busy      = (st_q != ST_IDLE);
   assign sym_data  = (st_q == ST_DATA) ? chunk : 8'h00;
   assign done      = done_q;

endmodule

// File: rtl/tx_pkt_assembler_chk.sv
module tx_pkt_assembler_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       go,
   input logic       sym_valid,
   input logic       sym_ready,
   input logic [1:0] sym_type,
   input logic [7:0] sym_data,
   input logic       busy,
   input logic       done,
   input logic [1:0] mode_q
);

   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!sym_valid && !busy && !done));

   assert_sop_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && sym_ready && sym_type == 2'd1) |=> (sym_valid && sym_type == 2'd2));

   assert_framing_zero_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && sym_type != 2'd3) |-> (sym_data == 8'h00));

   assert_two_bit_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && sym_type == 2'd3 && mode_q == 2'd1) |-> (sym_data[7:2] == 6'd0));

   assert_one_bit_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && sym_type == 2'd3 && mode_q[1]) |-> (sym_data[7:1] == 7'd0));

   assert_hold_while_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_type) && $stable(sym_data)));

   assert_busy_after_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy) |=> busy);

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(sym_valid && sym_ready) && !sym_valid));

endmodule

bind tx_pkt_assembler tx_pkt_assembler_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .go        (go),
   .sym_valid (sym_valid),
   .sym_ready (sym_ready),
   .sym_type  (sym_type),
   .sym_data  (sym_data),
   .busy      (busy),
   .done      (done),
   .mode_q    (mode_q)
);

// File: tb/test_tx_pkt_assembler.sv
`timescale 1ns/1ps
module test_tx_pkt_assembler;

   typedef struct packed {
      logic [4:0]  len;
      logic [1:0]  mode;
      logic [3:0]  pre;
      logic        crc;
      logic        ssel;
      logic [15:0] seed;
      logic [7:0]  base;
      logic [7:0]  step;
      logic [7:0]  rmask;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{5'd4,  2'd0, 4'd3, 1'b1, 1'b1, 16'hFFFF, 8'h11, 8'h22, 8'hFF},
      '{5'd16, 2'd1, 4'd1, 1'b1, 1'b0, 16'hABCD, 8'h80, 8'h03, 8'hB5},
      '{5'd20, 2'd2, 4'd0, 1'b1, 1'b1, 16'h1D0F, 8'h01, 8'h01, 8'hFF},
      '{5'd0,  2'd0, 4'd2, 1'b1, 1'b1, 16'h1234, 8'h55, 8'h01, 8'h6D},
      '{5'd5,  2'd3, 4'd2, 1'b0, 1'b1, 16'h0000, 8'hF0, 8'h11, 8'hFF},
      '{5'd3,  2'd1, 4'd0, 1'b0, 1'b0, 16'h0000, 8'hA5, 8'h5A, 8'h33}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [4:0]  cfg_len = '0;
   logic [1:0]  cfg_mode = '0;
   logic [3:0]  cfg_pre = '0;
   logic        cfg_crc_en = 1'b0;
   logic        cfg_seed_sel = 1'b0;
   logic [15:0] cfg_seed = '0;
   logic        go = 1'b0;
   logic        sym_ready = 1'b0;
   logic        sym_valid;
   logic [1:0]  sym_type;
   logic [7:0]  sym_data;
   logic        busy;
   logic        done;

   int n_checks = 0;
   int n_errors = 0;

   always #5 clk = ~clk;

   tx_pkt_assembler i_tx_pkt_assembler (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .cfg_len      (cfg_len),
      .cfg_mode     (cfg_mode),
      .cfg_pre      (cfg_pre),
      .cfg_crc_en   (cfg_crc_en),
      .cfg_seed_sel (cfg_seed_sel),
      .cfg_seed     (cfg_seed),
      .go           (go),
      .sym_valid    (sym_valid),
      .sym_ready    (sym_ready),
      .sym_type     (sym_type),
      .sym_data     (sym_data),
      .busy         (busy),
      .done         (done)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_crc(input logic [15:0] c0, input logic [7:0] b);
      logic [15:0] c = c0;
      for (int i = 7; i >= 0; i--) begin
         if (c[15] ^ b[i]) c = {c[14:0], 1'b0} ^ 16'h8005;
         else              c = {c[14:0], 1'b0};
      end
      return c;
   endfunction

   task automatic run_packet(input vec_t v, input bit reload, input bit poke);
      logic [9:0]  exp_s [256];
      logic [7:0]  bytes [20];
      int          nb, total, len, idx, k, nbits, per;
      logic [15:0] c;
      bit          fin, held;
      logic [9:0]  hv;
      logic [9:0]  act;
      len   = (v.len > 5'd16) ? 16 : int'(v.len);
      c     = v.ssel ? v.seed : 16'h0000;
      bytes[0] = 8'(len);
      for (int i = 0; i < len; i++) begin
         bytes[i + 1] = v.base + 8'(i) * v.step;
         c = ref_crc(c, bytes[i + 1]);
      end
      nb = len + 1;
      if (v.crc) begin
         bytes[nb]     = c[15:8];
         bytes[nb + 1] = c[7:0];
         nb += 2;
      end
      total = 0;
      for (int i = 0; i < int'(v.pre); i++) exp_s[total++] = {2'd0, 8'h00};
      exp_s[total++] = {2'd1, 8'h00};
      exp_s[total++] = {2'd2, 8'h00};
      nbits = (v.mode == 2'd0) ? 8 : (v.mode == 2'd1) ? 2 : 1;
      per   = 8 / nbits;
      for (int b = 0; b < nb; b++)
         for (int j = 0; j < per; j++)
            exp_s[total++] = {2'd3, 8'((bytes[b] >> (8 - nbits * (j + 1))) & ((1 << nbits) - 1))};

      if (reload) begin
         for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 4'(i); wr_data = v.base + 8'(i) * v.step;
         end
         @(negedge clk);
         wr_en = 1'b0;
      end

      @(negedge clk);
      cfg_len = v.len; cfg_mode = v.mode; cfg_pre = v.pre;
      cfg_crc_en = v.crc; cfg_seed_sel = v.ssel; cfg_seed = v.seed;
      go = 1'b1; sym_ready = 1'b0;
      idx = 0; k = 0; fin = 1'b0; held = 1'b0; hv = '0;
      while (!fin && k < 3000) begin
         @(negedge clk);
         k++;
         if (k == 1) go = 1'b0;
         if (poke && k == 2) begin
            wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'hEE; go = 1'b1;
         end
         if (poke && k == 3) begin
            wr_en = 1'b0; go = 1'b0;
         end
         sym_ready = v.rmask[k % 8];
         #1;
         act = {sym_type, sym_data};
         if (k == 1) chk(busy == 1'b1, "R8 busy after go", 32'(busy), 32'd1);
         if (held) begin
            chk(sym_valid && act == hv, "R7 symbol held while stalled", 32'(act), 32'(hv));
            held = 1'b0;
         end
         if (idx == total) begin
            chk(done && !sym_valid, "R9 done pulse after last symbol",
                32'({done, sym_valid}), 32'b10);
            fin = 1'b1;
         end else if (sym_valid && sym_ready) begin
            if (exp_s[idx][9:8] == 2'd3)
               chk(act == exp_s[idx], "R3 R4 R5 R6 data symbol", 32'(act), 32'(exp_s[idx]));
            else
               chk(act == exp_s[idx], "R2 framing symbol", 32'(act), 32'(exp_s[idx]));
            idx++;
         end else if (sym_valid) begin
            held = 1'b1;
            hv   = act;
         end else begin
            chk(1'b0, "R8 symbol stream stopped early", 32'(idx), 32'(total));
         end
      end
      if (!fin) chk(1'b0, "R9 packet did not finish", 32'(idx), 32'(total));
      @(negedge clk);
      sym_ready = 1'b0;
      #1;
      chk(!done && !sym_valid && !busy, "R8 R9 idle after done, no restart",
          32'({done, sym_valid, busy}), 32'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      #1;
      chk(!sym_valid && !busy && !done, "R1 outputs idle during reset",
          32'({sym_valid, busy, done}), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!sym_valid && !busy && !done, "R1 outputs idle after reset",
          32'({sym_valid, busy, done}), 32'd0);

      for (int v = 0; v < NV; v++) run_packet(VECS[v], 1'b1, 1'b0);

      // R8: write and go during a packet, then resend without reloading
      run_packet(VECS[0], 1'b1, 1'b1);
      run_packet(VECS[0], 1'b0, 1'b0);

      // R1: reset in the middle of a packet
      @(negedge clk);
      cfg_len = 5'd8; cfg_mode = 2'd2; cfg_pre = 4'd2; cfg_crc_en = 1'b1;
      go = 1'b1; sym_ready = 1'b1;
      @(negedge clk);
      go = 1'b0;
      repeat (6) @(negedge clk);
      #1;
      chk(sym_valid && busy, "R1 packet running before reset", 32'({sym_valid, busy}), 32'b11);
      rst_n = 1'b0;
      #1;
      chk(!sym_valid && !busy && !done, "R1 reset aborts packet",
          32'({sym_valid, busy, done}), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      sym_ready = 1'b0;
      @(negedge clk);
      #1;
      chk(!sym_valid && !busy, "R1 idle after mid-packet reset", 32'({sym_valid, busy}), 32'd0);
      run_packet(VECS[5], 1'b1, 1'b0);

      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule